// File: doc/BRIEF.md
# Edge-Sensed External Interrupt Port

This block takes seven off-chip pins, numbered 1 to 7, and turns each into an interrupt request line for a downstream interrupt controller. Every pin can also serve as a general-purpose input or output. A per-pin two-bit sense field picks low-level sensing or capture of rising, falling or either edge. Captured edges are held in a flag bit until software clears them by writing a one to that bit. In level mode the request simply follows the pin.

Software reaches the block through a small register window. The sense configuration sits in one halfword at offset 0. Direction, interrupt enable, output data, sampled pin levels and flags are each one byte at fixed offsets. Bit 0 of every register is a reserved slot with no pin behind it. Pins are brought into the clock domain by a two-flop synchroniser before anything looks at them. An edge is found by comparing the synchronised level with its value one cycle earlier.

Top module: `edge_irq_port`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `irq` are all zero, and each pin is an input in level mode with its interrupt disabled.
- R2: Reads are combinational on `rdata`. A write with `addr`=0 loads the 16-bit sense register from `wdata`. Writes to offsets 2 (direction), 3 (enable), 4 (output data) and 6 (flag clear) use `wdata[7:0]`. Offset 5 reads the pin levels. Bit 0 of every register, and bits 1:0 of the sense register, always read 0.
- R3: `pin_oe[p]` equals direction bit p and `pin_out[p]` equals output data bit p.
- R4: The offset-5 read shows bit p equal to `pin_in[p]` as sampled two clock edges earlier.
- R5: The sense field for pin p sits at bits 2p+1:2p, coded 00 low level, 01 rising, 10 falling, 11 both. In an edge mode, a matching edge sets the pin's flag on the third clock edge after the pin changes, whether or not the pin is enabled.
- R6: In level mode the flag bit reads 1 exactly while the synchronised pin is low, nothing is latched, and `irq[p]` is high while the pin is low and enabled.
- R7: In an edge mode `irq[p]` is the pin's flag AND its enable bit. `irq[p]` is never high while enable bit p is clear.
- R8: Writing a 1 to flag bit p clears a latched edge flag. Writing a 0 leaves it unchanged.
- R9: If an edge is detected in the same cycle as a clear write to that pin's flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| pin_in | input | 7 | External pin levels, pins 1 to 7 |
| pin_out | output | 7 | Output data for pins configured as outputs |
| pin_oe | output | 7 | Output enable per pin |
| irq | output | 7 | Interrupt request per pin |

## Verification
Each sense mode is driven with rising, falling and unchanging pin transitions on different pins. This separates a mode that fires on the right edge from one that fires on the wrong edge or on none. Enabled and disabled cases on the same transition separate flag capture from request gating. Level mode is tried with the pin held low and high to show that its flag tracks the pin and is not latched. A directed test lines up an edge with the clearing write in the same cycle to tell a lost event from a kept one, and a zero write shows that clearing needs a one.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'b00,
    SENSE_RISE  = 2'b01,
    SENSE_FALL  = 2'b10,
    SENSE_BOTH  = 2'b11
  } sense_e;

  localparam int unsigned AW       = 3;
  localparam logic [AW-1:0] OFS_SENSE = 3'd0;
  localparam logic [AW-1:0] OFS_DIR   = 3'd2;
  localparam logic [AW-1:0] OFS_IEN   = 3'd3;
  localparam logic [AW-1:0] OFS_DOUT  = 3'd4;
  localparam logic [AW-1:0] OFS_PINS  = 3'd5;
  localparam logic [AW-1:0] OFS_FLAG  = 3'd6;

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/edge_irq_chan.sv
module edge_irq_chan
  import edge_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e sense,
  input  logic   en,
  input  logic   pin_s,
  input  logic   clr,
  output logic   flag_rd,
  output logic   irq
);
  logic prev_q;
  logic flag_q;
  logic flag_d;
  logic edge_det;

  always_comb begin
    unique case (sense)
      SENSE_RISE: edge_det = pin_s & ~prev_q;
      SENSE_FALL: edge_det = ~pin_s & prev_q;
      SENSE_BOTH: edge_det = pin_s ^ prev_q;
      default:    edge_det = 1'b0;
    endcase
  end

  always_comb begin
    if (sense == SENSE_LEVEL) flag_d = 1'b0;
    else                      flag_d = (flag_q & ~clr) | edge_det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      flag_q <= flag_d;
    end
  end

  assign flag_rd = (sense == SENSE_LEVEL) ? ~pin_s : flag_q;
  assign irq     = en & flag_rd;

  assert_flag_from_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(edge_det));

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_det && flag_q) |=> !flag_q);

  assert_keep_on_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && edge_det) |=> flag_q);
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int unsigned RW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [2*RW-1:0] wdata,
  output logic [2*RW-1:0] rdata,
  input  logic [RW-1:0]   pin_s,
  input  logic [RW-1:0]   flag_rd,
  output logic [2*RW-1:0] sense_q,
  output logic [RW-1:0]   dir_q,
  output logic [RW-1:0]   ien_q,
  output logic [RW-1:0]   dout_q,
  output logic [RW-1:0]   clr
);
  localparam int unsigned SW = 2 * RW;
  localparam logic [RW-1:0] BYTE_MASK  = {{(RW-1){1'b1}}, 1'b0};
  localparam logic [SW-1:0] SENSE_MASK = {{(SW-2){1'b1}}, 2'b00};

  logic [SW-1:0] sense_d;
  logic [RW-1:0] dir_d, ien_d, dout_d;
  logic [RW-1:0] wbyte;

  assign wbyte = wdata[RW-1:0] & BYTE_MASK;

  always_comb begin
    sense_d = sense_q;
    dir_d   = dir_q;
    ien_d   = ien_q;
    dout_d  = dout_q;
    clr     = '0;
    if (wr_en) begin
      unique case (addr)
        OFS_SENSE: sense_d = wdata & SENSE_MASK;
        OFS_DIR:   dir_d   = wbyte;
        OFS_IEN:   ien_d   = wbyte;
        OFS_DOUT:  dout_d  = wbyte;
        OFS_FLAG:  clr     = wbyte;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      dout_q  <= '0;
    end else begin
      sense_q <= sense_d;
      dir_q   <= dir_d;
      ien_q   <= ien_d;
      dout_q  <= dout_d;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_SENSE: rdata = sense_q;
      OFS_DIR:   rdata = {{RW{1'b0}}, dir_q};
      OFS_IEN:   rdata = {{RW{1'b0}}, ien_q};
      OFS_DOUT:  rdata = {{RW{1'b0}}, dout_q};
      OFS_PINS:  rdata = {{RW{1'b0}}, pin_s & BYTE_MASK};
      OFS_FLAG:  rdata = {{RW{1'b0}}, flag_rd & BYTE_MASK};
      default:   rdata = '0;
    endcase
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[0] == 1'b0);
endmodule

// File: rtl/edge_irq_port.sv
module edge_irq_port
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  logic [2*NUM_PINS+1:0] wdata,
  output logic [2*NUM_PINS+1:0] rdata,
  input  logic [NUM_PINS:1]     pin_in,
  output logic [NUM_PINS:1]     pin_out,
  output logic [NUM_PINS:1]     pin_oe,
  output logic [NUM_PINS:1]     irq
);
  localparam int unsigned RW = NUM_PINS + 1;
  localparam int unsigned SW = 2 * RW;

  logic rst_meta_q, rst_sync_q;
  logic [NUM_PINS:1] pin_sync;
  logic [RW-1:0] pin_s, flag_rd, dir_q, ien_q, dout_q, clr;
  logic [SW-1:0] sense_q;
  logic unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  edge_irq_sync #(.W(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d     (pin_in),
    .q     (pin_sync)
  );

  assign pin_s      = {pin_sync, 1'b0};
  assign flag_rd[0] = 1'b0;

  edge_irq_regs #(.RW(RW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_s   (pin_s),
    .flag_rd (flag_rd),
    .sense_q (sense_q),
    .dir_q   (dir_q),
    .ien_q   (ien_q),
    .dout_q  (dout_q),
    .clr     (clr)
  );

  for (genvar p = 1; p <= NUM_PINS; p++) begin : g_pin
    edge_irq_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .sense   (sense_e'(sense_q[2*p +: 2])),
      .en      (ien_q[p]),
      .pin_s   (pin_s[p]),
      .clr     (clr[p]),
      .flag_rd (flag_rd[p]),
      .irq     (irq[p])
    );

    assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_sync_q)
      irq[p] |-> ien_q[p]);
  end

  assign pin_out     = dout_q[NUM_PINS:1];
  assign pin_oe      = dir_q[NUM_PINS:1];
  assign unused_bits = ^{sense_q[1:0], dir_q[0], ien_q[0], dout_q[0], clr[0]};

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(rst_sync_q) |-> (irq == '0 && pin_oe == '0));
endmodule

// File: tb/edge_irq_port_tb.sv
module edge_irq_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [7:1]  pin_in, pin_out, pin_oe, irq;

  int nvec = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  edge_irq_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {pin[2:0], mode[1:0], en, before, after, exp_flag, exp_irq}
  localparam logic [9:0] VEC [14] = '{
    {3'd1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R6 level low enabled
    {3'd1, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R6 level high
    {3'd4, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R6 low but disabled
    {3'd3, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R5 rise on rising
    {3'd3, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 rise on falling
    {3'd5, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 fall on falling
    {3'd5, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 fall on rising
    {3'd7, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R5 both on rising
    {3'd7, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 both on falling
    {3'd6, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R5 both, no change
    {3'd2, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R7 flag without enable
    {3'd6, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R7 fall disabled
    {3'd2, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R5 rise, no change
    {3'd7, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}   // R6 level held low
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; pin_in = 7'h7F;
    cyc(3);
    rst_n = 1'b1;
    cyc(5);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      if (a == 5) continue;
      rd(3'(a), r);
      chk($sformatf("R1 reg %0d", a), r, 16'h0000);
    end
    chk("R1 irq/oe", {2'b00, irq, pin_oe}, 16'h0000);

    // table walk
    for (int v = 0; v < 14; v++) begin
      int p;
      logic [9:0] e;
      e = VEC[v];
      p = int'(e[9:7]);
      wr(3'd0, 16'(e[6:5]) << (2 * p));
      wr(3'd3, 16'(e[4]) << p);
      pin_in = 7'h7F;
      pin_in[p] = e[3];
      cyc(6);
      wr(3'd6, 16'h00FE);
      pin_in[p] = e[2];
      cyc(6);
      chk($sformatf("R7 vec %0d irq", v), {15'd0, irq[p]}, {15'd0, e[0]});
      rd(3'd6, r);
      chk($sformatf("R5 vec %0d flag", v), {15'd0, r[p]}, {15'd0, e[1]});
    end

    // R2 halfword sense and reserved bits
    wr(3'd0, 16'hFFFF);
    rd(3'd0, r);
    chk("R2 sense reserved", r, 16'hFFFC);
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'hABFF);
    rd(3'd3, r);
    chk("R2 byte reserved", r, 16'h00FE);
    wr(3'd3, 16'h0000);

    // R3 direction and data
    wr(3'd2, 16'h00A6);
    wr(3'd4, 16'h000F);
    chk("R3 oe", {9'd0, pin_oe}, 16'h0053);
    chk("R3 out", {9'd0, pin_out}, 16'h0007);

    // R4 pin data via sync
    pin_in = 7'b0110101;
    cyc(3);
    rd(3'd5, r);
    chk("R4 pin data", r, 16'h006A);

    // R8 and R9 on pin 2, rising, enabled
    pin_in = 7'h7F; pin_in[2] = 1'b0;
    wr(3'd0, 16'h0010);
    wr(3'd3, 16'h0004);
    cyc(6);
    wr(3'd6, 16'h00FE);
    pin_in[2] = 1'b1;
    cyc(6);
    wr(3'd6, 16'h0000);
    cyc(2);
    chk("R8 zero write keeps", {15'd0, irq[2]}, 16'h0001);
    wr(3'd6, 16'h0004);
    cyc(2);
    chk("R8 one write clears", {15'd0, irq[2]}, 16'h0000);
    // falling is no edge in rising mode; go low, then align rise with clear
    pin_in[2] = 1'b0;
    cyc(6);
    @(negedge clk); pin_in[2] = 1'b1;   // edges E1,E2 follow; flag sets at E3
    @(negedge clk);                     // after E1
    @(negedge clk);                     // after E2: edge detected now
    wr_en = 1'b1; addr = 3'd6; wdata = 16'h0004;
    @(negedge clk);                     // E3 sampled clear with edge
    wr_en = 1'b0;
    cyc(2);
    chk("R9 clash keeps flag", {15'd0, irq[2]}, 16'h0001);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule